// File: doc/BRIEF.md
# Vector Branch Condition Reduction Unit

This unit settles a vector conditional branch once the per-element condition tests are known. It receives the active vector length, one condition-pass bit per element, an optional predicate mask and a set of mode controls. It reduces the surviving elements with either an AND or an OR and decides whether the branch is taken. It can also shorten the vector length at the element that decided the result, and it computes an updated loop counter.

Masked-out elements are handled in one of two ways. They are skipped, or they take part with a fixed fill value. A scalar-source mode looks at only the first element that survives predication. The amount taken off the counter can be chosen from four sources: the whole (possibly shortened) length, the number of enabled predicate bits, the number of passing elements, or the number of failing elements.

All results are captured in one register stage. They appear together with a single-cycle valid pulse one clock after the request.

Top module: `vbr_unit`

## Requirements
- R1: Element i is bit i of `elem_pass` and `pred_bits`. The legal `vec_len` values are 0 to 64. Elements at index `vec_len` or above have no effect on any result. With `vec_len` = 0, `red_all`=1 yields taken, `red_all`=0 yields not taken, `vec_len_out` is 0, and `ctr_out` equals `ctr_in`.
- R2: With `red_all`=0 (any mode), the branch is taken exactly when at least one participating element has its pass bit set.
- R3: With `red_all`=1 (all mode), the branch is taken exactly when no participating element fails.
- R4: When `pred_valid`=1, an element whose predicate bit is 0 is handled by `zero_masked`. With `zero_masked`=0 it does not participate. With `zero_masked`=1 it participates with the value `fill_val` in place of its pass bit.
- R5: With `scalar_src`=1, only the lowest-indexed participating element is tested, and all later elements are ignored.
- R6: The deciding element is the first failing participant in all mode, or the first passing participant in any mode. When `vlset_en`=1, truncation happens if taken equals `trunc_on_taken` and a deciding element exists. On truncation, `vec_len_out` is the deciding index, plus one when `keep_decider`=1. Otherwise `vec_len_out` equals `vec_len`.
- R7: With `ctr_en`=1 and `skip_count`=0, `ctr_out` is `ctr_in` minus `vec_len_out`, modulo 2^64.
- R8: With `ctr_en`=1, `skip_count`=1 and `pred_valid`=1, the amount subtracted is the number of set predicate bits below `vec_len_out`. This holds for either value of `zero_masked`.
- R9: With `ctr_en`=1, `skip_count`=1 and `pred_valid`=0, the amount subtracted is counted over elements below `vec_len_out`. With `zero_masked`=0 it is the number of passing elements. With `zero_masked`=1 it is the number of failing elements.
- R10: With `ctr_en`=0, `ctr_out` equals `ctr_in`.
- R11: Outputs update on the clock edge after a cycle with `in_valid`=1. `out_valid` is high for exactly that one cycle, and outputs hold their values otherwise. Reset clears `out_valid`, `br_taken`, `vec_len_out` and `ctr_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| vec_len | input | 7 | Active vector length, 0 to 64 |
| elem_pass | input | 64 | Per-element condition test results |
| pred_bits | input | 64 | Predicate mask |
| pred_valid | input | 1 | Predicate mask is in use |
| red_all | input | 1 | 1 = all mode (AND), 0 = any mode (OR) |
| zero_masked | input | 1 | Masked elements participate with the fill value |
| fill_val | input | 1 | Value substituted for masked elements |
| trunc_on_taken | input | 1 | Truncate on taken (1) or on not taken (0) |
| keep_decider | input | 1 | Include the deciding element in the new length |
| skip_count | input | 1 | Counter decrement is a selective count |
| ctr_en | input | 1 | Counter update enabled |
| vlset_en | input | 1 | Length truncation enabled |
| scalar_src | input | 1 | Test only the first participating element |
| ctr_in | input | 64 | Current counter |
| out_valid | output | 1 | Result strobe |
| br_taken | output | 1 | Branch decision |
| vec_len_out | output | 7 | Resulting vector length |
| ctr_out | output | 64 | Resulting counter |

## Verification
Directed patterns target the places where simpler logic would go wrong. Pass bits are placed beyond the length to show that range limiting works. A mask of 0b101 is run with both masked-element handlings to tell skipping apart from fill substitution. A scalar-source case places the first passing bit after the first enabled lane, which separates "first survivor" from "any survivor". Truncation cases vary `keep_decider` and counter modes to tell the pre-truncation length from the post-truncation length. Random requests with biased condition vectors exercise both reduction outcomes together with every counter source, including wraparound below zero.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    localparam int unsigned LANES = 64;
    localparam int unsigned CTR_W = 64;

    typedef enum logic {
        RED_ANY = 1'b0,
        RED_ALL = 1'b1
    } red_e;

    typedef enum logic [1:0] {
        AMT_LEN  = 2'd0,
        AMT_PRED = 2'd1,
        AMT_PASS = 2'd2,
        AMT_FAIL = 2'd3
    } amt_sel_e;

    typedef struct packed {
        red_e red;
        logic zero_masked;
        logic fill_val;
        logic trunc_on_taken;
        logic keep_decider;
        logic skip_count;
        logic ctr_en;
        logic vlset_en;
        logic scalar_src;
        logic pred_en;
    } mode_t;

    // Chooses which population feeds the counter decrement.
    function automatic amt_sel_e pick_amount(mode_t m);
        if (!m.skip_count)      return AMT_LEN;
        else if (m.pred_en)     return AMT_PRED;
        else if (m.zero_masked) return AMT_FAIL;
        else                    return AMT_PASS;
    endfunction

endpackage

// File: rtl/vbr_lane_filter.sv
module vbr_lane_filter
    import vbr_pkg::*;
#(
    parameter int unsigned N_LANES = vbr_pkg::LANES,
    localparam int unsigned VL_W   = $clog2(N_LANES + 1)
) (
    input  logic [VL_W-1:0]    vec_len,
    input  logic [N_LANES-1:0] elem_pass,
    input  logic [N_LANES-1:0] pred_bits,
    input  mode_t              mode,
    output logic [N_LANES-1:0] part_vec,
    output logic [N_LANES-1:0] pass_vec
);

    logic [N_LANES-1:0] raw_part;
    logic [N_LANES-1:0] val_vec;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic in_range;
        logic enabled;
        assign in_range    = VL_W'(g) < vec_len;
        assign enabled     = !mode.pred_en || pred_bits[g];
        assign raw_part[g] = in_range && (enabled || mode.zero_masked);
        assign val_vec[g]  = enabled ? elem_pass[g] : mode.fill_val;
    end

    // Scalar source keeps only the lowest surviving lane.
    always_comb begin
        if (mode.scalar_src) part_vec = raw_part & (~raw_part + N_LANES'(1));
        else                 part_vec = raw_part;
        pass_vec = part_vec & val_vec;
    end

endmodule

// File: rtl/vbr_decide.sv
module vbr_decide
    import vbr_pkg::*;
#(
    parameter int unsigned N_LANES = vbr_pkg::LANES,
    localparam int unsigned VL_W   = $clog2(N_LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VL_W-1:0]    vec_len,
    input  logic [N_LANES-1:0] part_vec,
    input  logic [N_LANES-1:0] pass_vec,
    input  mode_t              mode,
    output logic               taken,
    output logic [VL_W-1:0]    vl_next
);

    logic [N_LANES-1:0] fail_vec;
    logic [N_LANES-1:0] hit_vec;
    logic               found;
    logic [VL_W-1:0]    hit_idx;
    logic [VL_W-1:0]    cut_len;
    logic               do_trunc;

    assign fail_vec = part_vec & ~pass_vec;
    assign hit_vec  = (mode.red == RED_ALL) ? fail_vec : pass_vec;
    assign found    = |hit_vec;
    assign taken    = (mode.red == RED_ALL) ? !found : found;

    // Lowest set index of the deciding vector.
    always_comb begin
        hit_idx = '0;
        for (int i = N_LANES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = VL_W'(i);
        end
    end

    assign cut_len  = hit_idx + VL_W'(mode.keep_decider);
    assign do_trunc = mode.vlset_en && (mode.trunc_on_taken == taken) && found;
    assign vl_next  = do_trunc ? cut_len : vec_len;

    // R1: a deciding lane always lies inside the active length.
    p_decider_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        found |-> (hit_idx < vec_len));

    // R6: truncation never grows the length.
    p_trunc_shrinks_r6: assert property (@(posedge clk) disable iff (rst)
        vl_next <= vec_len);

endmodule

// File: rtl/vbr_ctr_step.sv
module vbr_ctr_step
    import vbr_pkg::*;
#(
    parameter int unsigned N_LANES = vbr_pkg::LANES,
    parameter int unsigned C_W     = vbr_pkg::CTR_W,
    localparam int unsigned VL_W   = $clog2(N_LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VL_W-1:0]    vl_eff,
    input  logic [N_LANES-1:0] elem_pass,
    input  logic [N_LANES-1:0] pred_bits,
    input  mode_t              mode,
    input  logic [C_W-1:0]     ctr_in,
    output logic [C_W-1:0]     ctr_next
);

    logic [N_LANES-1:0] lim_vec;
    logic [N_LANES-1:0] cnt_src;
    logic [VL_W-1:0]    pop;
    logic [VL_W-1:0]    amt;
    amt_sel_e           sel;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lim
        assign lim_vec[g] = VL_W'(g) < vl_eff;
    end

    assign sel = pick_amount(mode);

    always_comb begin
        unique case (sel)
            AMT_PRED: cnt_src = pred_bits;
            AMT_PASS: cnt_src = elem_pass;
            AMT_FAIL: cnt_src = ~elem_pass;
            default:  cnt_src = '0;
        endcase
    end

    always_comb begin
        pop = '0;
        for (int i = 0; i < N_LANES; i++) begin
            pop = pop + VL_W'(cnt_src[i] & lim_vec[i]);
        end
    end

    assign amt      = (sel == AMT_LEN) ? vl_eff : pop;
    assign ctr_next = mode.ctr_en ? (ctr_in - C_W'(amt)) : ctr_in;

    // R8: a selective count can never exceed the active length.
    p_amt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        amt <= vl_eff);

endmodule

// File: rtl/vbr_unit.sv
module vbr_unit
    import vbr_pkg::*;
#(
    parameter int unsigned N_LANES = vbr_pkg::LANES,
    parameter int unsigned C_W     = vbr_pkg::CTR_W,
    localparam int unsigned VL_W   = $clog2(N_LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VL_W-1:0]    vec_len,
    input  logic [N_LANES-1:0] elem_pass,
    input  logic [N_LANES-1:0] pred_bits,
    input  logic               pred_valid,
    input  logic               red_all,
    input  logic               zero_masked,
    input  logic               fill_val,
    input  logic               trunc_on_taken,
    input  logic               keep_decider,
    input  logic               skip_count,
    input  logic               ctr_en,
    input  logic               vlset_en,
    input  logic               scalar_src,
    input  logic [C_W-1:0]     ctr_in,
    output logic               out_valid,
    output logic               br_taken,
    output logic [VL_W-1:0]    vec_len_out,
    output logic [C_W-1:0]     ctr_out
);

    mode_t              mode;
    logic [N_LANES-1:0] part_vec;
    logic [N_LANES-1:0] pass_vec;
    logic               taken_c;
    logic [VL_W-1:0]    vl_c;
    logic [C_W-1:0]     ctr_c;

    always_comb begin
        mode.red            = red_all ? RED_ALL : RED_ANY;
        mode.zero_masked    = zero_masked;
        mode.fill_val       = fill_val;
        mode.trunc_on_taken = trunc_on_taken;
        mode.keep_decider   = keep_decider;
        mode.skip_count     = skip_count;
        mode.ctr_en         = ctr_en;
        mode.vlset_en       = vlset_en;
        mode.scalar_src     = scalar_src;
        mode.pred_en        = pred_valid;
    end

    vbr_lane_filter #(.N_LANES(N_LANES)) filt_i (
        .vec_len   (vec_len),
        .elem_pass (elem_pass),
        .pred_bits (pred_bits),
        .mode      (mode),
        .part_vec  (part_vec),
        .pass_vec  (pass_vec)
    );

    vbr_decide #(.N_LANES(N_LANES)) dec_i (
        .clk      (clk),
        .rst      (rst),
        .vec_len  (vec_len),
        .part_vec (part_vec),
        .pass_vec (pass_vec),
        .mode     (mode),
        .taken    (taken_c),
        .vl_next  (vl_c)
    );

    vbr_ctr_step #(.N_LANES(N_LANES), .C_W(C_W)) ctr_i (
        .clk       (clk),
        .rst       (rst),
        .vl_eff    (vl_c),
        .elem_pass (elem_pass),
        .pred_bits (pred_bits),
        .mode      (mode),
        .ctr_in    (ctr_in),
        .ctr_next  (ctr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            br_taken    <= 1'b0;
            vec_len_out <= '0;
            ctr_out     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                br_taken    <= taken_c;
                vec_len_out <= vl_c;
                ctr_out     <= ctr_c;
            end
        end
    end

    // R11: one result pulse per request, none otherwise.
    p_out_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_out_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10: counter passes through when its update is off.
    p_ctr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctr_en) |=> (ctr_out == $past(ctr_in)));

    // R1: an empty vector in all mode is taken.
    p_empty_all_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_len == '0 && red_all) |=> br_taken);

    // R6: the registered length never exceeds the requested one.
    p_len_bound_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (vec_len_out <= $past(vec_len)));

endmodule

// File: tb/vbr_unit_tb_top.sv
`timescale 1ns/1ps
module vbr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [6:0]  vec_len;
    logic [63:0] elem_pass, pred_bits, ctr_in;
    logic        pred_valid, red_all, zero_masked, fill_val, trunc_on_taken;
    logic        keep_decider, skip_count, ctr_en, vlset_en, scalar_src;
    logic        out_valid, br_taken;
    logic [6:0]  vec_len_out;
    logic [63:0] ctr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vbr_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vec_len(vec_len),
        .elem_pass(elem_pass), .pred_bits(pred_bits), .pred_valid(pred_valid),
        .red_all(red_all), .zero_masked(zero_masked), .fill_val(fill_val),
        .trunc_on_taken(trunc_on_taken), .keep_decider(keep_decider),
        .skip_count(skip_count), .ctr_en(ctr_en), .vlset_en(vlset_en),
        .scalar_src(scalar_src), .ctr_in(ctr_in), .out_valid(out_valid),
        .br_taken(br_taken), .vec_len_out(vec_len_out), .ctr_out(ctr_out)
    );

    typedef struct {
        int          vl;
        logic [63:0] cond, pm, ctr;
        bit          pe, all, zm, fv, tot, kd, sk, ce, vs, sc;
    } stim_s;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model(stim_s s, output bit tk, output int nvl,
                                  output logic [63:0] nc);
        int  ff = -1, fp = -1, dec, amt;
        bit  seen = 0, p, v;
        for (int i = 0; i < s.vl; i++) begin
            p = s.pe ? s.pm[i] : 1'b1;
            if (!p && !s.zm) continue;
            if (s.sc && seen) break;
            seen = 1;
            v = p ? s.cond[i] : s.fv;
            if (v && fp < 0) fp = i;
            if (!v && ff < 0) ff = i;
        end
        tk  = s.all ? (ff < 0) : (fp >= 0);
        dec = s.all ? ff : fp;
        nvl = s.vl;
        if (s.vs && (s.tot == tk) && dec >= 0) nvl = dec + int'(s.kd);
        amt = 0;
        if (!s.sk) amt = nvl;
        else for (int i = 0; i < nvl; i++) begin
            if (s.pe) amt += int'(s.pm[i]);
            else if (!s.zm) amt += int'(s.cond[i]);
            else amt += int'(!s.cond[i]);
        end
        nc = s.ce ? s.ctr - 64'(amt) : s.ctr;
    endfunction

    task automatic run(string tag, stim_s s);
        bit tk; int nvl; logic [63:0] nc;
        string t_tk, t_vl, t_ct;
        model(s, tk, nvl, nc);
        t_tk = (tag != "") ? tag : (s.all ? "R3" : "R2");
        t_vl = (tag != "") ? tag : "R6";
        t_ct = (tag != "") ? tag : (!s.ce ? "R10" : !s.sk ? "R7" : s.pe ? "R8" : "R9");
        @(negedge clk);
        vec_len = 7'(s.vl); elem_pass = s.cond; pred_bits = s.pm; ctr_in = s.ctr;
        pred_valid = s.pe; red_all = s.all; zero_masked = s.zm; fill_val = s.fv;
        trunc_on_taken = s.tot; keep_decider = s.kd; skip_count = s.sk;
        ctr_en = s.ce; vlset_en = s.vs; scalar_src = s.sc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11", "out_valid", 64'(out_valid), 64'd1);
        chk(t_tk, "taken", 64'(br_taken), 64'(tk));
        chk(t_vl, "vl", 64'(vec_len_out), 64'(nvl));
        chk(t_ct, "ctr", ctr_out, nc);
        @(negedge clk);
        chk("R11", "out_valid_drop", 64'(out_valid), 64'd0);
        chk("R11", "ctr_hold", ctr_out, nc);
    endtask

    function automatic stim_s blank();
        stim_s s;
        s.vl = 0; s.cond = '0; s.pm = '0; s.ctr = 64'd100;
        s.pe = 0; s.all = 0; s.zm = 0; s.fv = 0; s.tot = 0; s.kd = 0;
        s.sk = 0; s.ce = 0; s.vs = 0; s.sc = 0;
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        stim_s s;
        void'($urandom(32'h1d5e_7a01));
        rst = 1'b1; in_valid = 1'b0; vec_len = '0; elem_pass = '0; pred_bits = '0;
        ctr_in = '0; pred_valid = 0; red_all = 0; zero_masked = 0; fill_val = 0;
        trunc_on_taken = 0; keep_decider = 0; skip_count = 0; ctr_en = 0;
        vlset_en = 0; scalar_src = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11", "rst_valid", 64'(out_valid), 64'd0);
        chk("R11", "rst_taken", 64'(br_taken), 64'd0);
        chk("R11", "rst_vl", 64'(vec_len_out), 64'd0);
        chk("R11", "rst_ctr", ctr_out, 64'd0);

        // R1 empty vectors
        s = blank(); s.all = 1; s.ce = 1; s.cond = '1; run("R1", s);
        s = blank(); s.all = 0; s.ce = 1; s.cond = '1; run("R1", s);
        // R1 lanes beyond length ignored
        s = blank(); s.vl = 4; s.all = 1; s.cond = ~64'h2; run("R1", s);
        s = blank(); s.vl = 4; s.cond = 64'hFFFF_FFFF_FFFF_FFF0; run("R1", s);
        // R2 / R3
        s = blank(); s.vl = 64; s.cond = 64'h8000_0000_0000_0000; run("R2", s);
        s = blank(); s.vl = 64; s.all = 1; s.cond = '1; run("R3", s);
        // R4 skip vs fill with mask 0b101
        s = blank(); s.vl = 3; s.all = 1; s.pe = 1; s.pm = 64'b101; s.cond = 64'b101; run("R4", s);
        s.zm = 1; s.fv = 0; run("R4", s);
        s.fv = 1; run("R4", s);
        // R5 scalar source: first surviving lane only
        s = blank(); s.vl = 8; s.sc = 1; s.pe = 1; s.pm = 64'b1100; s.cond = 64'b0100; run("R5", s);
        s.cond = 64'b1000; run("R5", s);
        // R6 truncation
        s = blank(); s.vl = 10; s.vs = 1; s.tot = 1; s.cond = 64'h20; run("R6", s);
        s.kd = 1; run("R6", s);
        s = blank(); s.vl = 10; s.all = 1; s.vs = 1; s.tot = 0; s.cond = ~64'h8; run("R6", s);
        // R7 wrap and post-truncation length
        s = blank(); s.vl = 64; s.ce = 1; s.ctr = 64'd10; run("R7", s);
        s = blank(); s.vl = 10; s.vs = 1; s.tot = 1; s.cond = 64'h20; s.ce = 1; run("R7", s);
        // R8 predicate count, both masked handlings
        s = blank(); s.vl = 3; s.pe = 1; s.pm = 64'b101; s.cond = '1; s.ce = 1; s.sk = 1; run("R8", s);
        s.zm = 1; run("R8", s);
        // R9 pass and fail counts
        s = blank(); s.vl = 6; s.cond = 64'hF0_2B; s.ce = 1; s.sk = 1; run("R9", s);
        s.zm = 1; run("R9", s);
        // R10 counter untouched
        s = blank(); s.vl = 20; s.cond = 64'h5; s.ctr = 64'hDEAD; run("R10", s);

        for (int n = 0; n < 400; n++) begin
            s = blank();
            s.vl   = ($urandom % 4 == 0) ? int'($urandom % 9) : int'($urandom % 65);
            s.cond = {$urandom, $urandom};
            case ($urandom % 3)
                0: s.cond = ~({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
                1: s.cond = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
                default: ;
            endcase
            s.pm  = {$urandom, $urandom};
            s.ctr = ($urandom % 5 == 0) ? 64'($urandom % 40) : {$urandom, $urandom};
            {s.pe, s.all, s.zm, s.fv, s.tot, s.kd, s.sk, s.ce, s.vs} = 9'($urandom);
            s.sc = ($urandom % 5 == 0);
            run("", s);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule